// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Status Flags

This unit performs one of five integer operations per accepted cycle: add, subtract, increment, decrement and negate. Operands can be 8, 16 or 32 bits wide, chosen per operation by a size select. Each accepted operation registers a result and six status bits: carry, overflow, sign, zero, auxiliary (nibble) carry and parity. A datapath in front of it supplies two source values, an operation code, a size and a valid strobe. It reads the result and the flags on the cycle after the strobe.

All five operations share one adder. Subtraction, decrement and negate add the inverted subtrahend with a carry-in of one. For those three, the carry and nibble-carry outputs are borrows, so they are inverted. Increment and decrement leave the stored carry bit as it was. The result is always masked to the selected width. Flags come only from the bits inside that width, except parity, which always looks at the low byte.

Top module: `addsub_flags_unit`

## Requirements
- R1: With op code 0 (add), the registered result is (a + b) masked to the selected width, and carry is the carry out of that width's top bit.
- R2: With op code 1 (subtract), the result is (a - b) masked to the width, and carry is set exactly when b > a as unsigned values at that width (borrow).
- R3: Overflow is set when the signed result at the selected width is out of range. For example, 80h + 80h at 8 bits sets both carry and overflow.
- R4: Auxiliary carry is the carry out of bit 3 for addition and increment. For subtraction, decrement and negate it is the borrow into bit 4, i.e. it is set when the low nibble of the subtrahend exceeds that of the minuend.
- R5: Sign equals the result's top bit at the selected width. Zero is set when the masked result is all zeros.
- R6: Parity is set when bits 7..0 of the result hold an even number of ones, at every width.
- R7: Op code 2 (increment) gives a + 1 and op code 3 (decrement) gives a - 1. Both update every flag except carry, which keeps its previous value.
- R8: Op code 4 (negate) gives 0 - a. Its carry is set unless a is zero. Overflow is set only for the most negative value of the width. Auxiliary carry is clear when a's low nibble is zero.
- R9: Size code 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Result bits above the selected width read zero.
- R10: When valid is low, or the op code is 5, 6 or 7, the result and all flags keep their values.
- R11: After reset, the result and all six flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Accept the operation this cycle |
| op_i | input | 3 | Operation code (0 add, 1 sub, 2 inc, 3 dec, 4 neg) |
| size_i | input | 2 | Operand width select (0: 8, 1: 16, 2/3: 32) |
| src_a_i | input | 32 | Destination/first operand |
| src_b_i | input | 32 | Source/second operand |
| result_o | output | 32 | Registered result, zero above selected width |
| cf_o | output | 1 | Carry / borrow flag |
| of_o | output | 1 | Signed overflow flag |
| sf_o | output | 1 | Sign flag |
| zf_o | output | 1 | Zero flag |
| af_o | output | 1 | Nibble carry / borrow flag |
| pf_o | output | 1 | Even-parity flag of low byte |

## Verification
The only state is the result and flag register, so any corruption shows on the ports one cycle after the accepted operation. The carry bit is the exception. It survives increment and decrement unchanged, so a wrongly stored carry can stay hidden through a run of those operations and appear only when a later add, subtract or negate should have overwritten it, or be compared directly while it is held. Each cycle the bench compares every output against a behavioural model built on integer arithmetic. Directed cases cover sign boundaries, zero and the most negative value at each width.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned HALF_W = 2 * BYTE_W;
    localparam int unsigned WORD_W = 4 * BYTE_W;
    localparam int unsigned NIB_W  = BYTE_W / 2;
    localparam int unsigned OP_W   = 3;
    localparam int unsigned SZ_W   = 2;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_INC = 3'd2,
        OP_DEC = 3'd3,
        OP_NEG = 3'd4
    } op_e;

    typedef enum logic [SZ_W-1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_ALT  = 2'd3
    } size_e;

    typedef struct packed {
        logic cf;
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic pf;
    } flags_t;

    function automatic logic op_is_borrow(input logic [OP_W-1:0] op);
        return (op == OP_SUB) || (op == OP_DEC) || (op == OP_NEG);
    endfunction

    function automatic logic op_keeps_carry(input logic [OP_W-1:0] op);
        return (op == OP_INC) || (op == OP_DEC);
    endfunction

    function automatic logic op_legal(input logic [OP_W-1:0] op);
        return op <= OP_NEG;
    endfunction

endpackage

// File: rtl/addsub_adder.sv
module addsub_adder
    import addsub_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W
) (
    input  logic [OP_W-1:0]   op_i,
    input  logic [SZ_W-1:0]   size_i,
    input  logic [DATA_W-1:0] src_a_i,
    input  logic [DATA_W-1:0] src_b_i,
    output logic [DATA_W-1:0] sum_o,
    output logic [DATA_W:0]   carry_in_o
);

    localparam int unsigned EXT_W = DATA_W + 1;

    logic [DATA_W-1:0] width_mask;
    logic [DATA_W-1:0] opx;
    logic [DATA_W-1:0] opy;
    logic [DATA_W-1:0] opy_inv;
    logic [EXT_W-1:0]  ext_sum;
    logic              borrow_mode;

    // width mask from size select
    always_comb begin
        unique case (size_i)
            SZ_BYTE: width_mask = DATA_W'({BYTE_W{1'b1}});
            SZ_HALF: width_mask = DATA_W'({HALF_W{1'b1}});
            default: width_mask = {DATA_W{1'b1}};
        endcase
    end

    // operand steering: every operation is x + y' + cin
    always_comb begin
        borrow_mode = op_is_borrow(op_i);
        unique case (op_i)
            OP_ADD, OP_SUB: begin
                opx = src_a_i;
                opy = src_b_i;
            end
            OP_INC, OP_DEC: begin
                opx = src_a_i;
                opy = DATA_W'(1);
            end
            OP_NEG: begin
                opx = '0;
                opy = src_a_i;
            end
            default: begin
                opx = src_a_i;
                opy = src_b_i;
            end
        endcase
        opx     = opx & width_mask;
        opy     = opy & width_mask;
        opy_inv = borrow_mode ? ~opy : opy;
    end

    always_comb begin
        ext_sum = {1'b0, opx} + {1'b0, opy_inv} + EXT_W'(borrow_mode);
        sum_o   = ext_sum[DATA_W-1:0] & width_mask;
    end

    // carry into each bit position; top entry is the final carry out
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_carry
        assign carry_in_o[gi] = opx[gi] ^ opy_inv[gi] ^ ext_sum[gi];
    end
    assign carry_in_o[DATA_W] = ext_sum[DATA_W];

endmodule

// File: rtl/addsub_flag_gen.sv
module addsub_flag_gen
    import addsub_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W
) (
    input  logic [OP_W-1:0]   op_i,
    input  logic [SZ_W-1:0]   size_i,
    input  logic [DATA_W-1:0] sum_i,
    input  logic [DATA_W:0]   carry_in_i,
    input  logic              prev_cf_i,
    output flags_t            flags_o
);

    int unsigned msb_idx;
    logic        cout_msb;
    logic        cin_msb;
    logic        nib_carry;
    logic        borrow_mode;

    always_comb begin
        unique case (size_i)
            SZ_BYTE: msb_idx = BYTE_W - 1;
            SZ_HALF: msb_idx = HALF_W - 1;
            default: msb_idx = DATA_W - 1;
        endcase
    end

    always_comb begin
        borrow_mode = op_is_borrow(op_i);
        cout_msb    = carry_in_i[msb_idx + 1];
        cin_msb     = carry_in_i[msb_idx];
        nib_carry   = carry_in_i[NIB_W];

        flags_o.cf = op_keeps_carry(op_i) ? prev_cf_i
                                          : (cout_msb ^ borrow_mode);
        flags_o.of = cout_msb ^ cin_msb;
        flags_o.sf = sum_i[msb_idx];
        flags_o.zf = (sum_i == '0);
        flags_o.af = nib_carry ^ borrow_mode;
        flags_o.pf = ~(^sum_i[BYTE_W-1:0]);
    end

endmodule

// File: rtl/addsub_flags_unit.sv
module addsub_flags_unit
    import addsub_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [2:0]        op_i,
    input  logic [1:0]        size_i,
    input  logic [DATA_W-1:0] src_a_i,
    input  logic [DATA_W-1:0] src_b_i,
    output logic [DATA_W-1:0] result_o,
    output logic              cf_o,
    output logic              of_o,
    output logic              sf_o,
    output logic              zf_o,
    output logic              af_o,
    output logic              pf_o
);

    typedef struct packed {
        logic [DATA_W-1:0] result;
        flags_t            flags;
    } state_t;

    state_t            state_d;
    state_t            state_q;
    logic [DATA_W-1:0] sum_w;
    logic [DATA_W:0]   carry_w;
    flags_t            flags_w;
    logic              accept_w;

    addsub_adder #(.DATA_W(DATA_W)) adder_i (
        .op_i       (op_i),
        .size_i     (size_i),
        .src_a_i    (src_a_i),
        .src_b_i    (src_b_i),
        .sum_o      (sum_w),
        .carry_in_o (carry_w)
    );

    addsub_flag_gen #(.DATA_W(DATA_W)) flag_gen_i (
        .op_i       (op_i),
        .size_i     (size_i),
        .sum_i      (sum_w),
        .carry_in_i (carry_w),
        .prev_cf_i  (state_q.flags.cf),
        .flags_o    (flags_w)
    );

    always_comb begin
        accept_w = valid_i && op_legal(op_i);
        state_d  = state_q;
        if (accept_w) begin
            state_d.result = sum_w;
            state_d.flags  = flags_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result_o = state_q.result;
    assign cf_o     = state_q.flags.cf;
    assign of_o     = state_q.flags.of;
    assign sf_o     = state_q.flags.sf;
    assign zf_o     = state_q.flags.zf;
    assign af_o     = state_q.flags.af;
    assign pf_o     = state_q.flags.pf;

    // ---------------- assertions ----------------
    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i || op_i > 3'd4) |=>
            ($stable(result_o) && $stable({cf_o, of_o, sf_o, zf_o, af_o, pf_o})));

    assert_keep_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (op_i == 3'd2 || op_i == 3'd3)) |=> (cf_o == $past(cf_o)));

    assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i <= 3'd4) |=> (zf_o == (result_o == '0)));

    assert_parity_low_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i <= 3'd4) |=> (pf_o == ~(^result_o[BYTE_W-1:0])));

    assert_byte_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i <= 3'd4 && size_i == 2'd0) |=>
            (result_o[DATA_W-1:BYTE_W] == '0 && sf_o == result_o[BYTE_W-1]));

    assert_neg_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 3'd4 && src_a_i == '0) |=> (!cf_o && !of_o && zf_o));

endmodule

// File: tb/addsub_flags_unit_tb_top.sv
`timescale 1ns/1ps
module addsub_flags_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  sz = '0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [31:0] result;
    logic        cf, of, sf, zf, af, pf;

    int total = 0;
    int fails = 0;

    logic [31:0] e_res = '0;
    logic        e_cf = 0, e_of = 0, e_sf = 0, e_zf = 0, e_af = 0, e_pf = 0;

    always #2.5 clk = ~clk;

    addsub_flags_unit dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid), .op_i(op), .size_i(sz),
        .src_a_i(a), .src_b_i(b), .result_o(result),
        .cf_o(cf), .of_o(of), .sf_o(sf), .zf_o(zf), .af_o(af), .pf_o(pf)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string op_tag(input logic v, input logic [2:0] o);
        if (!v || o > 3'd4) return "R10";
        case (o)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd4: return "R8";
            default: return "R7";
        endcase
    endfunction

    function automatic longint sext(input longint v, input int w);
        if ((v >> (w - 1)) & 1) return v - (longint'(1) << w);
        return v;
    endfunction

    // behavioural model of one accepted step
    task automatic model(input logic v, input logic [2:0] o, input logic [1:0] s,
                         input logic [31:0] av, input logic [31:0] bv);
        int w;
        longint mask, x, y, r, sr, smax, smin;
        logic is_sub, keep;
        int ones;
        if (!v || o > 3'd4) return;
        w = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
        mask = (longint'(1) << w) - 1;
        keep = 0;
        case (o)
            3'd0: begin x = av & mask; y = bv & mask; is_sub = 0; end
            3'd1: begin x = av & mask; y = bv & mask; is_sub = 1; end
            3'd2: begin x = av & mask; y = 1; is_sub = 0; keep = 1; end
            3'd3: begin x = av & mask; y = 1; is_sub = 1; keep = 1; end
            default: begin x = 0; y = av & mask; is_sub = 1; end
        endcase
        smax = (longint'(1) << (w - 1)) - 1;
        smin = -(longint'(1) << (w - 1));
        if (is_sub) begin
            r  = x - y;
            sr = sext(x, w) - sext(y, w);
            if (!keep) e_cf = (x < y);
            e_af = ((x & 15) < (y & 15));
        end else begin
            r  = x + y;
            sr = sext(x, w) + sext(y, w);
            if (!keep) e_cf = (r > mask);
            e_af = (((x & 15) + (y & 15)) > 15);
        end
        r = r & mask;
        e_res = 32'(r);
        e_of = (sr > smax) || (sr < smin);
        e_zf = (r == 0);
        e_sf = ((r >> (w - 1)) & 1) != 0;
        ones = 0;
        for (int i = 0; i < 8; i++) ones += int'((r >> i) & 1);
        e_pf = (ones % 2) == 0;
    endtask

    task automatic step(input logic v, input logic [2:0] o, input logic [1:0] s,
                        input logic [31:0] av, input logic [31:0] bv);
        string t;
        @(negedge clk);
        valid = v; op = o; sz = s; a = av; b = bv;
        model(v, o, s, av, bv);
        t = op_tag(v, o);
        @(posedge clk);
        #1;
        chk(t, "result", result, e_res);
        chk(t, "carry", 32'(cf), 32'(e_cf));
        chk("R3", "overflow", 32'(of), 32'(e_of));
        chk("R5", "sign", 32'(sf), 32'(e_sf));
        chk("R5", "zero", 32'(zf), 32'(e_zf));
        chk("R4", "auxcarry", 32'(af), 32'(e_af));
        chk("R6", "parity", 32'(pf), 32'(e_pf));
    endtask

    function automatic logic [31:0] pick(input logic [31:0] rnd, input logic [2:0] k);
        case (k)
            3'd0: return 32'h0;
            3'd1: return 32'h80;
            3'd2: return 32'h7FFF;
            3'd3: return 32'h8000_0000;
            3'd4: return 32'hFFFF_FFFF;
            default: return rnd;
        endcase
    endfunction

    initial begin : watchdog
        #(200000 * 5);
        fails++;
        total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        chk("R11", "reset result", result, 32'h0);
        chk("R11", "reset flags", 32'({cf, of, sf, zf, af, pf}), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3/R1: 80h + 80h at byte width
        step(1, 3'd0, 2'd0, 32'h80, 32'h80);
        chk("R3", "80h+80h carry&overflow", 32'({cf, of, zf}), 32'b111);
        // R2: equal subtract gives zero, no borrow
        step(1, 3'd1, 2'd2, 32'h1234_5678, 32'h1234_5678);
        chk("R2", "equal sub zero", 32'({cf, zf}), 32'b01);
        // R7: carry held across inc/dec
        step(1, 3'd1, 2'd0, 32'h01, 32'h02);
        step(1, 3'd2, 2'd1, 32'h7FFF, 32'h0);
        chk("R7", "inc keeps carry, overflows", 32'({cf, of, sf}), 32'b111);
        step(1, 3'd3, 2'd0, 32'h00, 32'h0);
        chk("R7", "dec 0 -> FF", result, 32'hFF);
        // R8: negate corners
        step(1, 3'd4, 2'd0, 32'h00, 32'h0);
        chk("R8", "neg 0 carry", 32'(cf), 32'h0);
        step(1, 3'd4, 2'd0, 32'h80, 32'h0);
        chk("R8", "neg min overflow", 32'({cf, of}), 32'b11);
        step(1, 3'd4, 2'd1, 32'h10, 32'h0);
        chk("R8", "neg nibble-zero auxcarry", 32'(af), 32'h0);
        step(1, 3'd4, 2'd2, 32'h8000_0000, 32'h0);
        // R9: size 3 is 32-bit; byte upper bits cleared
        step(1, 3'd0, 2'd3, 32'hFFFF_FFFF, 32'h1);
        chk("R9", "size3 wide carry", 32'({cf, zf}), 32'b11);
        step(1, 3'd0, 2'd0, 32'hABCD_12F0, 32'h5555_0011);
        chk("R9", "byte upper zero", result, 32'h0000_0001);
        // R6: parity on low byte at word width
        step(1, 3'd0, 2'd2, 32'h0001_0000, 32'h0000_0003);
        chk("R6", "parity low byte only", 32'(pf), 32'h1);
        // R10: illegal op and idle hold
        step(1, 3'd6, 2'd2, 32'h1, 32'h1);
        step(0, 3'd0, 2'd2, 32'h5, 32'h7);
        chk("R10", "idle holds result", result, 32'h0001_0003);

        for (int n = 0; n < 600; n++) begin
            logic [31:0] r1, r2;
            r1 = $urandom;
            r2 = $urandom;
            step(($urandom % 8) != 0, 3'($urandom % 8), 2'($urandom % 4),
                 pick(r1, 3'($urandom % 8)), pick(r2, 3'($urandom % 8)));
        end

        @(negedge clk);
        valid = 1'b0;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule